// File: doc/BRIEF.md
# Analog Comparator Control and Interrupt Logic

This block is the digital side of an analog voltage comparator. The comparator's raw decision enters as an asynchronous level. It passes through a synchronizer, and the synchronized level then drives two things. The first is an interrupt flag that is set on the edge software selects. The second is the choice between two reference codes for the reference ladder, which gives the comparator hysteresis.

The block also tells the analog side several things: whether the comparator is on, which input terminal the generated reference feeds, and which source the ladder divides (the supply or the precision reference). It forwards the two input-multiplexer selects. For each of sixteen analog-capable pins it produces a digital input-buffer disable. That disable comes from a software mask and is forced for any pin that one of the two multiplexers has selected.

Software configures the block through a small write-only register port. The port has four word addresses, and one of them clears the flag by writing a one.

Top module: `cmp_ctrl_top`

## Requirements
- R1: Every output derived from the comparator decision (the flag and the reference code) reflects `cmp_raw_i` through a two-stage synchronizer. A level change driven between clock edges reaches `ref_code_o` just after the second rising edge that follows it.
- R2: With the edge-select bit at 0, a rising edge of the synchronized decision sets the flag and a falling edge does not. With the bit at 1, the roles are swapped.
- R3: The flag watches the synchronized decision XOR the edge-select bit. Toggling the edge-select bit can therefore set the flag on its own. Moving the bit 0 to 1 while the decision is 0 sets the flag, as does moving it 1 to 0 while the decision is 1. The other two toggles do not set the flag. This behaviour is the same when the comparator enable bit is 0.
- R4: Writing address 3 with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged. A set event in the same cycle as a clear wins, and the flag stays 1.
- R5: `irq_o` is 1 exactly when the flag is 1 and the interrupt-enable bit is 1.
- R6: `ref_code_o` equals the upper code while the synchronized decision is 1 and the lower code while it is 0.
- R7: `ref_on_neg_o`, `ref_src_o`, `cmp_en_o`, `pos_sel_o` and `neg_sel_o` follow their control fields one cycle after the write.
- R8: Bit i of `buf_dis_o` is 1 whenever mask bit i is 1.
- R9: While the comparator is enabled, `buf_dis_o` also has a 1 at the pin index given by the positive select and at the one given by the negative select. While it is disabled, `buf_dis_o` equals the mask exactly.
- R10: After reset, every register and output is 0.
- R11: Register map, with a write taking effect on the edge that samples `reg_we`:
  - Address 0 is control: bit 0 comparator enable, bit 1 edge select, bit 2 interrupt enable, bit 3 reference on negative terminal, bit 4 reference source, bits 11:8 positive select, bits 15:12 negative select.
  - Address 1 holds the lower code in bits 4:0 and the upper code in bits 12:8.
  - Address 2 is the 16-bit buffer-disable mask.
  - Address 3 is the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| cmp_en_o | output | 1 | Comparator power enable to analog |
| ref_src_o | output | 1 | Ladder source: 0 supply, 1 precision reference |
| ref_on_neg_o | output | 1 | Reference feeds the negative terminal when 1 |
| ref_code_o | output | 5 | Reference ladder tap code |
| pos_sel_o | output | 4 | Positive input multiplexer select |
| neg_sel_o | output | 4 | Negative input multiplexer select |
| flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |
| buf_dis_o | output | 16 | Per-pin digital input-buffer disables |

## Verification
The bench sweeps all 256 select pairs with the comparator both on and off. A design that ignored the enable, or decoded only one multiplexer, would leave a selected pin's buffer live or force a buffer it should not.

It toggles the edge-select bit in all four decision/bit combinations with the comparator off. A design that edge-detects the raw decision alone would miss the flag that must appear, and one that sets on any change would raise a flag that must not appear.

It lands a flag clear on the exact edge where a set arrives. A design that lets the clear win loses that edge.

It also samples the reference code one cycle too early and one on time, which exposes a synchronizer with the wrong number of stages.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int PIN_N  = 16;
    localparam int SEL_W  = $clog2(PIN_N);
    localparam int CODE_W = 5;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_REFS = 2'd1,
        REG_MASK = 2'd2,
        REG_FLAG = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SEL_W-1:0] neg_sel;
        logic [SEL_W-1:0] pos_sel;
        logic             ref_src;
        logic             ref_on_neg;
        logic             irq_en;
        logic             edge_fall;
        logic             cmp_on;
    } ctrl_t;

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
    } refs_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.cmp_on     = d[0];
        c.edge_fall  = d[1];
        c.irq_en     = d[2];
        c.ref_on_neg = d[3];
        c.ref_src    = d[4];
        c.pos_sel    = d[8 +: SEL_W];
        c.neg_sel    = d[12 +: SEL_W];
        return c;
    endfunction

    function automatic refs_t unpack_refs(input logic [DATA_W-1:0] d);
        refs_t r;
        r.lo = d[0 +: CODE_W];
        r.hi = d[8 +: CODE_W];
        return r;
    endfunction

endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_pkg::*;
#(
    parameter int N_PINS = PIN_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output refs_t             refs,
    output logic [N_PINS-1:0] mask,
    output logic              clr_pulse
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[7:5], wdata[15:13]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            refs <= '0;
            mask <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                REG_CTRL: ctrl <= unpack_ctrl(wdata);
                REG_REFS: refs <= unpack_refs(wdata);
                REG_MASK: mask <= wdata[N_PINS-1:0];
                default:  ;
            endcase
        end
    end

    assign clr_pulse = we && (reg_addr_e'(addr) == REG_FLAG) && wdata[0];

endmodule

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic edge_fall,
    input  logic clr,
    output logic flag
);

    logic watch, watch_q, set_evt;

    assign watch   = level ^ edge_fall;
    assign set_evt = watch & ~watch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            watch_q <= 1'b0;
            flag    <= 1'b0;
        end else begin
            watch_q <= watch;
            if (set_evt)  flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

    // R2 R3 R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);

    // R4
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_evt) |=> !flag);

endmodule

// File: rtl/cmp_ref_sel.sv
module cmp_ref_sel
    import cmp_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          level,
    input  logic [CW-1:0] code_lo,
    input  logic [CW-1:0] code_hi,
    output logic [CW-1:0] code
);

    assign code = level ? code_hi : code_lo;

    // R6
    hyst_up_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |-> (code == code_hi));

    // R6
    hyst_dn_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |-> (code == code_lo));

endmodule

// File: rtl/cmp_pin_dis.sv
module cmp_pin_dis #(
    parameter int N_PINS = 16,
    parameter int SW     = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [SW-1:0]     pos_sel,
    input  logic [SW-1:0]     neg_sel,
    input  logic [N_PINS-1:0] mask,
    output logic [N_PINS-1:0] dis
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic picked;
        assign picked = (pos_sel == SW'(i)) || (neg_sel == SW'(i));
        assign dis[i] = mask[i] | (enable & picked);
    end

    // R8
    mask_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (dis & mask) == mask);

    // R9
    sel_force_chk: assert property (@(posedge clk) disable iff (rst)
        enable |-> (dis[pos_sel] && dis[neg_sel]));

    // R9
    sel_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (dis == mask));

endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top
    import cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cmp_raw_i,
    output logic              cmp_en_o,
    output logic              ref_src_o,
    output logic              ref_on_neg_o,
    output logic [CODE_W-1:0] ref_code_o,
    output logic [SEL_W-1:0]  pos_sel_o,
    output logic [SEL_W-1:0]  neg_sel_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic [PIN_N-1:0]  buf_dis_o
);

    ctrl_t            ctrl;
    refs_t            refs;
    logic [PIN_N-1:0] mask;
    logic             clr_pulse;
    logic             level;

    cmp_regs #(.N_PINS(PIN_N)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl(ctrl), .refs(refs), .mask(mask), .clr_pulse(clr_pulse)
    );

    cmp_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(cmp_raw_i), .q_sync(level)
    );

    cmp_edge_flag u_flag (
        .clk(clk), .rst(rst), .level(level), .edge_fall(ctrl.edge_fall),
        .clr(clr_pulse), .flag(flag_o)
    );

    cmp_ref_sel #(.CW(CODE_W)) u_ref (
        .clk(clk), .rst(rst), .level(level), .code_lo(refs.lo),
        .code_hi(refs.hi), .code(ref_code_o)
    );

    cmp_pin_dis #(.N_PINS(PIN_N), .SW(SEL_W)) u_pins (
        .clk(clk), .rst(rst), .enable(ctrl.cmp_on), .pos_sel(ctrl.pos_sel),
        .neg_sel(ctrl.neg_sel), .mask(mask), .dis(buf_dis_o)
    );

    assign cmp_en_o     = ctrl.cmp_on;
    assign ref_src_o    = ctrl.ref_src;
    assign ref_on_neg_o = ctrl.ref_on_neg;
    assign pos_sel_o    = ctrl.pos_sel;
    assign neg_sel_o    = ctrl.neg_sel;
    assign irq_o        = flag_o & ctrl.irq_en;

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!flag_o && !irq_o && buf_dis_o == '0 && ref_code_o == '0));

endmodule

// File: tb/tb_cmp_ctrl_top.sv
module tb_cmp_ctrl_top;
    import cmp_pkg::*;

    logic              clk = 0;
    logic              rst = 1;
    logic              reg_we = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              cmp_raw_i = 0;
    logic              cmp_en_o, ref_src_o, ref_on_neg_o, flag_o, irq_o;
    logic [CODE_W-1:0] ref_code_o;
    logic [SEL_W-1:0]  pos_sel_o, neg_sel_o;
    logic [PIN_N-1:0]  buf_dis_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 0;

    always #4 clk = ~clk;

    cmp_ctrl_top dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] ctrl_word(input logic on, es, ie, rn, rs,
                                             input logic [3:0] p, n);
        return {n, p, 3'b000, rs, rn, ie, es, on};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R10 reset state
        check("R10 flag", flag_o, 0);
        check("R10 irq", irq_o, 0);
        check("R10 dis", buf_dis_o, 0);
        check("R10 code", ref_code_o, 0);
        check("R10 ctl", {cmp_en_o, ref_src_o, ref_on_neg_o, pos_sel_o, neg_sel_o}, 0);

        // R7 R11 pass-through fields
        wr(0, ctrl_word(1, 0, 0, 1, 0, 4'd5, 4'd9));
        check("R7 on/neg/sel", {cmp_en_o, ref_src_o, ref_on_neg_o, pos_sel_o, neg_sel_o},
              {1'b1, 1'b0, 1'b1, 4'd5, 4'd9});
        wr(0, ctrl_word(0, 0, 0, 0, 1, 4'd3, 4'd12));
        check("R7 src/sel", {cmp_en_o, ref_src_o, ref_on_neg_o, pos_sel_o, neg_sel_o},
              {1'b0, 1'b1, 1'b0, 4'd3, 4'd12});

        // R6 R1 hysteresis and synchronizer latency
        for (int k = 0; k < 4; k++) begin
            logic [4:0] lo, hi;
            lo = 5'(3 + 7 * k); hi = 5'(31 - 5 * k);
            wr(1, {3'b000, hi, 3'b000, lo});
            cyc(3);
            check("R6 low code", ref_code_o, lo);
            cmp_raw_i = 1;               // driven at negedge
            cyc(1);                      // one edge passed
            check("R1 not yet", ref_code_o, lo);
            cyc(1);                      // second edge passed
            check("R1 R6 high code", ref_code_o, hi);
            cmp_raw_i = 0;
            cyc(2);
            check("R6 back low", ref_code_o, lo);
        end

        // R2 edge sweep, R5 irq gating
        for (int es = 0; es < 2; es++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    logic exp_f;
                    wr(0, ctrl_word(1, es[0], ie[0], 0, 0, 4'd0, 4'd1));
                    cmp_raw_i = ~dir[0];
                    cyc(4);
                    wr(3, 16'h0001);
                    cyc(1);
                    check("R4 cleared", flag_o, 0);
                    cmp_raw_i = dir[0];
                    cyc(4);
                    exp_f = (es == 0) ? (dir == 1) : (dir == 0);
                    check("R2 edge flag", flag_o, exp_f);
                    check("R5 irq", irq_o, exp_f & ie[0]);
                end
            end
        end

        // R3 edge-select toggles with comparator off
        for (int lvl = 0; lvl < 2; lvl++) begin
            for (int from = 0; from < 2; from++) begin
                wr(0, ctrl_word(0, from[0], 0, 0, 0, 4'd0, 4'd0));
                cmp_raw_i = lvl[0];
                cyc(4);
                wr(3, 16'h0001);
                cyc(1);
                wr(0, ctrl_word(0, ~from[0], 0, 0, 0, 4'd0, 4'd0));
                cyc(2);
                check("R3 toggle flag", flag_o, (lvl == 0) ? (from == 0) : (from == 1));
            end
        end

        // R4 write of zero does not clear
        wr(0, ctrl_word(1, 0, 1, 0, 0, 4'd0, 4'd0));
        cmp_raw_i = 0; cyc(4);
        wr(3, 16'h0001); cyc(1);
        cmp_raw_i = 1; cyc(4);
        check("R4 set before", flag_o, 1);
        wr(3, 16'hFFFE); cyc(1);
        check("R4 zero write ignored", flag_o, 1);
        check("R5 irq on", irq_o, 1);
        wr(3, 16'h0001); cyc(1);
        check("R4 clear", flag_o, 0);
        check("R5 irq off", irq_o, 0);

        // R4 set wins over simultaneous clear
        cmp_raw_i = 0; cyc(4);
        wr(3, 16'h0001); cyc(1);
        cmp_raw_i = 1;                   // at negedge
        @(posedge clk); @(posedge clk);  // level now high, set pending on next edge
        @(negedge clk);
        reg_we = 1; reg_addr = 2'd3; reg_wdata = 16'h0001;
        @(negedge clk);                  // clear and set sampled on same edge
        reg_we = 0;
        check("R4 set wins", flag_o, 1);

        // R8 R9 exhaustive select sweep
        for (int on = 0; on < 2; on++) begin
            for (int p = 0; p < 16; p++) begin
                for (int n = 0; n < 16; n++) begin
                    logic [15:0] m, exp_d;
                    m = 16'(16'hA51C ^ (p * 16'h0111) ^ (n << 3));
                    wr(2, m);
                    wr(0, ctrl_word(on[0], 0, 0, 0, 0, 4'(p), 4'(n)));
                    exp_d = m;
                    if (on == 1) exp_d = exp_d | (16'd1 << p) | (16'd1 << n);
                    check(on ? "R9 forced" : "R8 R9 mask only", buf_dis_o, exp_d);
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule